// File: doc/BRIEF.md
# Boundary-scan test access port

This block is a serial test port controller. It runs on the test clock `tck` and steps a sixteen-state controller on `tms`. It holds a 10-bit instruction and moves bits from `tdi` to `tdo` through the data path that the instruction selects. The available paths are a one-bit pass-through stage, a 32-bit identification word, a 32-bit user code word, and a boundary chain with two cells per modelled pin. Two further paths lead out to scan chains that fabric logic builds. Each of those chains receives its own select and capture, shift and update strobes, and returns its serial data on `usr_tdo`.

The block also decides where each modelled pin takes its value and its enable from. In normal function both come from the core. Under the external-test instruction they come from the boundary update stage. The high-impedance instruction turns every enable off. The clamp instruction freezes the pins at the update-stage values while the one-bit stage carries the scan path. Fabric chains read `tdi` directly and shift on the rising edge of `tck` while their shift strobe is high.

Top module: `bscan_tap`

## Requirements
- R1: Five consecutive rising `tck` edges with `tms` high return the controller to Test-Logic-Reset from any state, and reset loads the identification instruction.
- R2: After reset, a 32-bit data scan shifts out the `IDCODE_VAL` parameter, least significant bit first. The same happens after loading opcode 0x006.
- R3: During an instruction scan, the first ten bits out are 1 followed by nine 0s, because Capture-IR loads 0x001 into the instruction shift stage.
- R4: Opcode 0x3FF, and any opcode not listed here, selects the one-bit stage. That stage captures 0, so a data scan returns a 0 and then `tdi` delayed by one bit.
- R5: Opcode 0x007 makes a 32-bit data scan shift out the `USERCODE_VAL` parameter, least significant bit first.
- R6: `tdo` changes only on falling `tck` edges. `tdo_oe` is high only in the falling-edge half cycles of Shift-IR and Shift-DR.
- R7: Opcode 0x005 (sample/preload) captures `{core_oe, pin_in}` into the boundary chain, with pin i data at bit i and its enable at bit NPINS+i. Update-DR loads the update stage. The pins keep their core values.
- R8: Opcode 0x00F (external test) drives `pin_out` and `pin_oe` from the update stage. Its data scans capture the same fields as R7 and refresh the update stage.
- R9: Opcode 0x00B (high impedance) forces every `pin_oe` bit low and uses the one-bit scan path.
- R10: Opcode 0x00A (clamp) holds the pins at the update-stage values whatever the core drives, and uses the one-bit scan path.
- R11: Opcodes 0x00C and 0x00E assert `usr_sel` bit 0 or bit 1 respectively. The matching `usr_capture`, `usr_shift` and `usr_update` bit is high in Capture-DR, Shift-DR and Update-DR, and `tdo` carries that chain's `usr_tdo` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in (shared with fabric chains) |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` is valid |
| pin_in | input | NPINS | Values observed at the modelled pins |
| core_out | input | NPINS | Core output data for normal function |
| core_oe | input | NPINS | Core output enables for normal function |
| pin_out | output | NPINS | Selected pin output data |
| pin_oe | output | NPINS | Selected pin output enables |
| usr_sel | output | 2 | One bit per fabric chain, high while its opcode is active |
| usr_capture | output | 2 | Per-chain capture strobe |
| usr_shift | output | 2 | Per-chain shift strobe |
| usr_update | output | 2 | Per-chain update strobe |
| usr_tdo | input | 2 | Serial return data of each fabric chain |

## Verification
Two things can change on the same rising edge: the Update-IR edge that switches pin control, and an instruction being replaced. When sample/preload gives way to external test, the pins must move to the preloaded update stage on that same edge. The bench reads the pins one half cycle later and compares them against the pattern it preloaded. An external-test data scan then captures pins that the block itself is driving while the update stage is being rewritten. The bench checks that the captured bits are the observed inputs and that the new drive values appear only after Update-DR.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IRW = 10;

  localparam logic [IRW-1:0] OP_SAMPLE = 10'h005;
  localparam logic [IRW-1:0] OP_IDCODE = 10'h006;
  localparam logic [IRW-1:0] OP_UCODE  = 10'h007;
  localparam logic [IRW-1:0] OP_CLAMP  = 10'h00A;
  localparam logic [IRW-1:0] OP_HIGHZ  = 10'h00B;
  localparam logic [IRW-1:0] OP_USR0   = 10'h00C;
  localparam logic [IRW-1:0] OP_USR1   = 10'h00E;
  localparam logic [IRW-1:0] OP_EXTEST = 10'h00F;
  localparam logic [IRW-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IRW-1:0] IR_CAPT   = 10'h001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR,
    ST_EX2_DR, ST_UP_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR,
    ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_state_e;

  typedef enum logic [3:0] {
    PATH_BYP, PATH_ID, PATH_UC, PATH_SAMP, PATH_EXT, PATH_HIGHZ,
    PATH_CLAMP, PATH_U0, PATH_U1
  } path_e;

  function automatic path_e decode(input logic [IRW-1:0] op);
    case (op)
      OP_SAMPLE: return PATH_SAMP;
      OP_EXTEST: return PATH_EXT;
      OP_IDCODE: return PATH_ID;
      OP_UCODE:  return PATH_UC;
      OP_HIGHZ:  return PATH_HIGHZ;
      OP_CLAMP:  return PATH_CLAMP;
      OP_USR0:   return PATH_U0;
      OP_USR1:   return PATH_U1;
      default:   return PATH_BYP;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UP_IR  : ST_SH_IR;
      default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_reset,
  input  logic           cap,
  input  logic           sh,
  input  logic           upd,
  input  logic           tdi,
  output logic [IRW-1:0] ir_sh,
  output logic [IRW-1:0] ir_act
);
  always_ff @(posedge clk) begin
    if (rst || in_reset) begin
      ir_sh  <= IR_CAPT;
      ir_act <= OP_IDCODE;
    end else begin
      if (cap)      ir_sh  <= IR_CAPT;
      else if (sh)  ir_sh  <= {tdi, ir_sh[IRW-1:1]};
      if (upd)      ir_act <= ir_sh;
    end
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int          NPINS        = 4,
  parameter logic [31:0] IDCODE_VAL   = 32'h0312_60DD,
  parameter logic [31:0] USERCODE_VAL = 32'hCAFE_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cap,
  input  logic               sh,
  input  logic               upd,
  input  path_e              path,
  input  logic               tdi,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [NPINS-1:0]   core_oe,
  output logic               dr_lsb,
  output logic [2*NPINS-1:0] bsr_upd
);
  localparam int BSR_LEN = 2 * NPINS;
  localparam int DRW     = (BSR_LEN > 32) ? BSR_LEN : 32;

  logic [DRW-1:0] dr_sh;
  logic [DRW-1:0] shifted;
  logic [DRW:0]   ext;
  int             len;
  logic           bsr_path;

  assign bsr_path = (path == PATH_SAMP) || (path == PATH_EXT);

  always_comb begin
    case (path)
      PATH_ID, PATH_UC:    len = 32;
      PATH_SAMP, PATH_EXT: len = BSR_LEN;
      default:             len = 1;
    endcase
  end

  assign ext = {1'b0, dr_sh};

  always_comb begin
    for (int i = 0; i < DRW; i++)
      shifted[i] = (i == len - 1) ? tdi : ext[i+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_sh   <= '0;
      bsr_upd <= '0;
    end else begin
      if (cap) begin
        dr_sh <= '0;
        case (path)
          PATH_ID:             dr_sh[31:0]        <= IDCODE_VAL;
          PATH_UC:             dr_sh[31:0]        <= USERCODE_VAL;
          PATH_SAMP, PATH_EXT: dr_sh[BSR_LEN-1:0] <= {core_oe, pin_in};
          default:             ;
        endcase
      end else if (sh) begin
        dr_sh <= shifted;
      end
      if (upd && bsr_path) bsr_upd <= dr_sh[BSR_LEN-1:0];
    end
  end

  assign dr_lsb = dr_sh[0];
endmodule

// File: rtl/tap_pins.sv
module tap_pins
  import tap_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  path_e              path,
  input  logic [2*NPINS-1:0] bsr_upd,
  input  logic [NPINS-1:0]   core_out,
  input  logic [NPINS-1:0]   core_oe,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    always_comb begin
      case (path)
        PATH_EXT, PATH_CLAMP: begin
          pin_out[p] = bsr_upd[p];
          pin_oe[p]  = bsr_upd[NPINS+p];
        end
        PATH_HIGHZ: begin
          pin_out[p] = core_out[p];
          pin_oe[p]  = 1'b0;
        end
        default: begin
          pin_out[p] = core_out[p];
          pin_oe[p]  = core_oe[p];
        end
      endcase
    end
  end
endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import tap_pkg::*;
#(
  parameter int          NPINS        = 4,
  parameter logic [31:0] IDCODE_VAL   = 32'h0312_60DD,
  parameter logic [31:0] USERCODE_VAL = 32'hCAFE_0001
) (
  input  logic             tck,
  input  logic             rst,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic [1:0]       usr_sel,
  output logic [1:0]       usr_capture,
  output logic [1:0]       usr_shift,
  output logic [1:0]       usr_update,
  input  logic [1:0]       usr_tdo
);
  tap_state_e         state;
  logic [IRW-1:0]     ir_sh;
  logic [IRW-1:0]     ir_act;
  path_e              path;
  logic               dr_lsb;
  logic [2*NPINS-1:0] bsr_upd;
  logic               sh_ir, sh_dr, cap_dr, upd_dr;
  logic               tdo_q, tdo_oe_q;

  assign sh_ir  = (state == ST_SH_IR);
  assign sh_dr  = (state == ST_SH_DR);
  assign cap_dr = (state == ST_CAP_DR);
  assign upd_dr = (state == ST_UP_DR);
  assign path   = decode(ir_act);

  tap_fsm u_fsm (.clk(tck), .rst(rst), .tms(tms), .state(state));

  tap_ir u_ir (
    .clk(tck), .rst(rst), .in_reset(state == ST_RESET),
    .cap(state == ST_CAP_IR), .sh(sh_ir), .upd(state == ST_UP_IR),
    .tdi(tdi), .ir_sh(ir_sh), .ir_act(ir_act)
  );

  tap_dr #(.NPINS(NPINS), .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)) u_dr (
    .clk(tck), .rst(rst), .cap(cap_dr), .sh(sh_dr), .upd(upd_dr),
    .path(path), .tdi(tdi), .pin_in(pin_in), .core_oe(core_oe),
    .dr_lsb(dr_lsb), .bsr_upd(bsr_upd)
  );

  tap_pins #(.NPINS(NPINS)) u_pins (
    .path(path), .bsr_upd(bsr_upd), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  assign usr_sel     = {path == PATH_U1, path == PATH_U0};
  assign usr_capture = {2{cap_dr}} & usr_sel;
  assign usr_shift   = {2{sh_dr}}  & usr_sel;
  assign usr_update  = {2{upd_dr}} & usr_sel;

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_oe_q <= sh_ir || sh_dr;
      if (sh_ir)           tdo_q <= ir_sh[0];
      else if (usr_sel[0]) tdo_q <= usr_tdo[0];
      else if (usr_sel[1]) tdo_q <= usr_tdo[1];
      else                 tdo_q <= dr_lsb;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = tdo_oe_q;
endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import tap_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tms,
  input tap_state_e       state,
  input logic [IRW-1:0]   ir_sh,
  input logic [IRW-1:0]   ir_act,
  input logic             tdo_oe,
  input logic [NPINS-1:0] pin_oe,
  input logic [1:0]       usr_sel,
  input logic [1:0]       usr_shift
);
  p_five_high_reset_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> state == ST_RESET);

  p_reset_loads_id_r2: assert property (@(posedge clk) disable iff (rst)
    state == ST_RESET |=> ir_act == OP_IDCODE);

  p_capture_ir_r3: assert property (@(posedge clk) disable iff (rst)
    state == ST_CAP_IR |=> ir_sh[1:0] == 2'b01);

  p_oe_in_shift_r6: assert property (@(posedge clk) disable iff (rst)
    tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

  p_highz_off_r9: assert property (@(posedge clk) disable iff (rst)
    ir_act == OP_HIGHZ |-> pin_oe == '0);

  p_user_sel_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(usr_sel) && ((usr_shift & ~usr_sel) == 2'b00));
endmodule

bind bscan_tap bscan_tap_chk #(.NPINS(NPINS)) chk_i (
  .clk(tck), .rst(rst), .tms(tms), .state(state), .ir_sh(ir_sh),
  .ir_act(ir_act), .tdo_oe(tdo_oe), .pin_oe(pin_oe),
  .usr_sel(usr_sel), .usr_shift(usr_shift)
);

// File: tb/bscan_tap_tb_top.sv
module bscan_tap_tb_top;
  localparam int          CLK_P  = 10;
  localparam int          NP     = 4;
  localparam logic [31:0] ID_V   = 32'h0312_60DD;
  localparam logic [31:0] UC_V   = 32'hCAFE_0001;
  localparam int          NVEC   = 8;
  // {opcode[73:64], data in[63:32], expected out[31:0]}
  localparam logic [73:0] VEC [NVEC] = '{
    {10'h006, 32'h0000_0000, ID_V},
    {10'h007, 32'h0000_0000, UC_V},
    {10'h3FF, 32'hA5A5_0F0F, 32'h4B4A_1E1E},
    {10'h003, 32'h1234_5678, 32'h2468_ACF0},
    {10'h00B, 32'h8000_0001, 32'h0000_0002},
    {10'h00A, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
    {10'h00C, 32'h5555_5555, 32'h0000_0000},
    {10'h00E, 32'h0000_0000, 32'hFFFF_FFFF}
  };

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo, tdo_oe;
  logic [NP-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [1:0]    usr_sel, usr_capture, usr_shift, usr_update;
  logic [1:0]    usr_tdo = 2'b10;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) tck = ~tck;

  bscan_tap #(.NPINS(NP), .IDCODE_VAL(ID_V), .USERCODE_VAL(UC_V)) dut_i (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .usr_sel(usr_sel),
    .usr_capture(usr_capture), .usr_shift(usr_shift),
    .usr_update(usr_update), .usr_tdo(usr_tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [31:0] din,
                      output logic [31:0] dout, output bit oe_ok, output bit stable_ok);
    step(1, 0);
    if (is_ir) step(1, 0);
    step(0, 0);
    step(0, 0);
    dout = '0; oe_ok = 1; stable_ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo;
      if (!tdo_oe) oe_ok = 0;
      tms = (i == n - 1); tdi = din[i];
      @(posedge tck); #1;
      if (tdo !== dout[i]) stable_ok = 0;
    end
    step(1, 0);
    step(0, 0);
    @(negedge tck); #1;
    if (tdo_oe) oe_ok = 0;
  endtask

  task automatic load_ir(input logic [9:0] op);
    logic [31:0] o; bit a, b;
    scan(1, 10, {22'd0, op}, o, a, b);
    check("R3 ir capture pattern", {22'd0, o[9:0]}, 32'h001);
    check("R6 tdo_oe/tdo edge in ir scan", {30'd0, a, b}, 32'h3);
  endtask

  task automatic dr32(input logic [31:0] din, input logic [31:0] exp, input string req);
    logic [31:0] o; bit a, b;
    scan(0, 32, din, o, a, b);
    check(req, o, exp);
    check("R6 tdo_oe/tdo edge in dr scan", {30'd0, a, b}, 32'h3);
  endtask

  initial begin
    #(CLK_P * 40000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] o; bit a, b;
    repeat (3) @(posedge tck);
    #1 rst = 1'b0;
    check("R6 reset tdo_oe low", {31'd0, tdo_oe}, 32'd0);
    check("R11 reset no user select", {30'd0, usr_sel}, 32'd0);
    step(0, 0);
    dr32(32'h0, ID_V, "R2 idcode after reset");

    // table walk: R2 R4 R5 R9 R10 R11 scan paths
    for (int v = 0; v < NVEC; v++) begin
      load_ir(VEC[v][73:64]);
      dr32(VEC[v][63:32], VEC[v][31:0], $sformatf("R4/R5/R11 vector %0d", v));
    end

    // R1 from Shift-DR: five tms-high edges
    load_ir(10'h3FF);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    dr32(32'h0, ID_V, "R1 five tms high then idcode");

    // R11 per-chain strobes
    load_ir(10'h00E);
    check("R11 user1 select", {30'd0, usr_sel}, 32'h2);
    step(1, 0); step(0, 0);
    check("R11 user1 capture", {30'd0, usr_capture}, 32'h2);
    step(0, 0);
    check("R11 user1 shift", {30'd0, usr_shift}, 32'h2);
    step(1, 0); step(1, 0);
    check("R11 user1 update", {30'd0, usr_update}, 32'h2);
    step(0, 0);

    // R7 sample/preload
    pin_in = 4'hA; core_oe = 4'h6; core_out = 4'h9;
    load_ir(10'h005);
    scan(0, 8, 32'hF3, o, a, b);
    check("R7 sample capture", o, 32'h6A);
    check("R7 pins stay normal", {24'd0, pin_oe, pin_out}, 32'h69);

    // R8 external test
    load_ir(10'h00F);
    check("R8 extest drives preload", {24'd0, pin_oe, pin_out}, 32'hF3);
    pin_in = 4'h6;
    scan(0, 8, 32'h5C, o, a, b);
    check("R8 extest capture", o, 32'h66);
    check("R8 extest new drive", {24'd0, pin_oe, pin_out}, 32'h5C);

    // R10 clamp
    load_ir(10'h00A);
    core_out = 4'h0; core_oe = 4'hF;
    #1 check("R10 clamp holds pins", {24'd0, pin_oe, pin_out}, 32'h5C);

    // R9 high impedance
    load_ir(10'h00B);
    check("R9 highz enables off", {28'd0, pin_oe}, 32'h0);

    // R4 bypass releases pins
    load_ir(10'h3FF);
    check("R4 bypass pins normal", {24'd0, pin_oe, pin_out}, 32'hF0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule